// File: doc/BRIEF.md
# NAND Flash Byte-Transfer Sequencer

This block moves a software-programmed run of bytes across the NAND flash data pins, one strobe cycle per byte. Software writes one control word. That word gives the number of bytes, the direction, whether the bytes come from (or go to) a 32-entry internal byte buffer or a single 16-bit data register, the buffer location to start at, and a start bit. The engine then pulses the read strobe or the write strobe once per byte. In a write it drives the outgoing byte. In a read it captures the incoming byte on the rising edge of the strobe.

After each byte the buffer location advances, so a read-back of the control word shows where the transfer stopped. The start bit falls by itself after the last byte. If enabled, a completion flag is raised and held until software clears it. A soft-reset input abandons a transfer at once. Command and address phases, error-correcting codes and pin-level timing are handled elsewhere.

Top module: `nand_xfer_seq`

## Requirements
- R1: After reset the control word reads 0, both strobes are high, the data pins are not driven, the data register reads 0 and the interrupt is low.
- R2: The control word maps as follows. Bits 12:8 hold the count, and exactly count+1 bytes are moved. Bit 7 selects the buffer (1) or the data register (0). Bits 6:2 hold the buffer location. Bit 1 is start. Bit 0 is the direction, read = 1 and write = 0. A control write with start = 1 launches the transfer on the following cycle.
- R3: Each byte holds its strobe low for LO_CYC cycles and then high for HI_CYC cycles. A read uses only the read strobe. A write uses only the write strobe and drives the data pins (output enable high) for the whole byte.
- R4: A read byte is captured at the clock edge where its strobe rises. In buffer mode it goes into buffer[location]. In register mode the data register shifts left by 8 bits, and the new byte enters at bits 7:0.
- R5: A written byte comes from buffer[location] in buffer mode, or from data register bits 7:0 in register mode.
- R6: The location field goes up by one after each byte and wraps modulo 32. The count field decrements after each byte except the last, so it reads 0 at the end.
- R7: The start bit reads 1 while the transfer runs and falls to 0 on the edge that ends its last byte.
- R8: While a transfer runs, writes to the control word, the data register and the buffer are ignored.
- R9: A soft reset stops the transfer on the next edge: start reads 0, both strobes are high, and no interrupt is raised. A control write in the same cycle as a soft reset is ignored.
- R10: Completing the last byte with the interrupt enable high sets the interrupt. It stays set until a clear request. If a completion and a clear fall in the same cycle, the interrupt is set.
- R11: A buffer read request returns buffer[address] on the read-data port one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Abort the current transfer |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 13 | Control word write data |
| ctl_rdata | output | 13 | Control word read-back (live count, location, start) |
| dreg_we | input | 1 | Data register write enable |
| dreg_wdata | input | 16 | Data register write data |
| dreg_rdata | output | 16 | Data register contents |
| buf_we | input | 1 | Buffer write enable |
| buf_re | input | 1 | Buffer read request |
| buf_addr | input | 5 | Buffer address for host access |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle after the request |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Clear the completion interrupt |
| irq | output | 1 | Completion interrupt |
| nf_io_in | input | 8 | Data from the flash pins |
| nf_io_out | output | 8 | Data to the flash pins |
| nf_io_oe | output | 1 | Drive enable for the flash data pins |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_we_n | output | 1 | Write strobe, active low |

## Verification
Completion of the last byte can fall in the same cycle as a software interrupt clear, and also in the same cycle as a soft reset. A soft reset can coincide with a fresh control write. The bench drives each of these collisions in the exact cycle, which it finds from the state of its own cycle model. Its model decides the winner independently: the completion beats the clear, and the soft reset beats both the completion and the control write. The interrupt, the start bit and the strobes are then compared with that model on every clock.

// File: rtl/nand_xfer_seq.sv
module nand_xfer_seq #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        ctl_we,
  input  logic [12:0] ctl_wdata,
  output logic [12:0] ctl_rdata,
  input  logic        dreg_we,
  input  logic [15:0] dreg_wdata,
  output logic [15:0] dreg_rdata,
  input  logic        buf_we,
  input  logic        buf_re,
  input  logic [4:0]  buf_addr,
  input  logic [7:0]  buf_wdata,
  output logic [7:0]  buf_rdata,
  input  logic        irq_en,
  input  logic        irq_clr,
  output logic        irq,
  input  logic [7:0]  nf_io_in,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  output logic        nf_re_n,
  output logic        nf_we_n
);
  localparam int PTR_W = 5;
  localparam int CNT_W = 5;
  localparam int DEPTH = 1 << PTR_W;
  localparam int TW = $clog2(LO_CYC + HI_CYC) + 1;

  logic             busy, ph, use_buf, dir, irq_q;
  logic [TW-1:0]    tmr;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      dreg;
  logic [7:0]       brd;
  logic [7:0]       mem [DEPTH];

  wire lo_end = !ph && tmr == TW'(LO_CYC - 1);
  wire hi_end = ph && tmr == TW'(HI_CYC - 1);
  wire last   = busy && hi_end && cnt == '0 && !soft_rst;
  wire cap    = busy && lo_end && dir && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; tmr <= '0; cnt <= '0;
      ptr <= '0; use_buf <= 1'b0; dir <= 1'b0;
    end else if (soft_rst) begin
      busy <= 1'b0; ph <= 1'b0; tmr <= '0;
    end else if (busy) begin
      if (lo_end) begin
        ph <= 1'b1; tmr <= '0;
      end else if (hi_end) begin
        ph <= 1'b0; tmr <= '0; ptr <= ptr + 1'b1;
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (ctl_we) begin
      cnt     <= ctl_wdata[12:8];
      use_buf <= ctl_wdata[7];
      ptr     <= ctl_wdata[6:2];
      busy    <= ctl_wdata[1];
      dir     <= ctl_wdata[0];
      ph      <= 1'b0;
      tmr     <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (cap && use_buf) mem[ptr] <= nf_io_in;
    else if (!busy && buf_we) mem[buf_addr] <= buf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreg <= '0;
    else if (cap && !use_buf) dreg <= {dreg[7:0], nf_io_in};
    else if (!busy && dreg_we) dreg <= dreg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brd <= '0;
    else if (buf_re) brd <= mem[buf_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (last && irq_en) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign ctl_rdata  = {cnt, use_buf, ptr, busy, dir};
  assign dreg_rdata = dreg;
  assign buf_rdata  = brd;
  assign irq        = irq_q;
  assign nf_re_n    = !(busy && dir && !ph);
  assign nf_we_n    = !(busy && !dir && !ph);
  assign nf_io_oe   = busy && !dir;
  assign nf_io_out  = use_buf ? mem[ptr] : dreg[7:0];
endmodule

module nand_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        irq_en,
  input logic        irq_clr,
  input logic [12:0] ctl_rdata,
  input logic        nf_re_n,
  input logic        nf_we_n,
  input logic        nf_io_oe,
  input logic        irq
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_re_n && !nf_we_n));
  // R3
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_io_oe |-> (ctl_rdata[1] && !ctl_rdata[0]));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1] |=> ($stable(ctl_rdata[7]) && $stable(ctl_rdata[0])));
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ctl_rdata[1] && nf_re_n && nf_we_n));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_rdata[1]) && !$past(soft_rst) && $past(irq_en)) |-> irq);
endmodule

bind nand_xfer_seq nand_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_en(irq_en),
  .irq_clr(irq_clr), .ctl_rdata(ctl_rdata), .nf_re_n(nf_re_n),
  .nf_we_n(nf_we_n), .nf_io_oe(nf_io_oe), .irq(irq)
);

// File: tb/nand_xfer_seq_test.sv
module nand_xfer_seq_test;
  localparam int PERIOD = 10;
  localparam int LO = 2;
  localparam int HI = 2;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic ctl_we = 1'b0, dreg_we = 1'b0, buf_we = 1'b0, buf_re = 1'b0;
  logic [12:0] ctl_wdata = '0;
  logic [15:0] dreg_wdata = '0;
  logic [4:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0, nf_io_in = 8'h11;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic [12:0] ctl_rdata;
  logic [15:0] dreg_rdata;
  logic [7:0]  buf_rdata, nf_io_out;
  logic nf_io_oe, nf_re_n, nf_we_n, irq;

  nand_xfer_seq #(.LO_CYC(LO), .HI_CYC(HI)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural cycle model
  int m_busy, m_ph, m_t, m_cnt, m_ptr, m_use, m_dir, m_dreg, m_irq, m_brd;
  int m_mem [32];
  bit m_lo, m_hi, m_fin, m_cap;
  initial foreach (m_mem[i]) m_mem[i] = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_t = 0; m_cnt = 0; m_ptr = 0; m_use = 0;
      m_dir = 0; m_dreg = 0; m_irq = 0; m_brd = 0;
    end else begin
      m_lo  = m_busy && !m_ph && m_t == LO-1;
      m_hi  = m_busy && m_ph && m_t == HI-1;
      m_fin = m_hi && m_cnt == 0 && !soft_rst;
      m_cap = m_lo && m_dir && !soft_rst;
      if (buf_re) m_brd = m_mem[buf_addr];
      if (m_cap) begin
        if (m_use) m_mem[m_ptr] = nf_io_in;
        else m_dreg = ((m_dreg << 8) & 16'hff00) | nf_io_in;
      end
      if (!m_busy && buf_we) m_mem[buf_addr] = buf_wdata;
      if (!m_busy && dreg_we) m_dreg = dreg_wdata;
      if (m_fin && irq_en) m_irq = 1; else if (irq_clr) m_irq = 0;
      if (soft_rst) begin
        m_busy = 0; m_ph = 0; m_t = 0;
      end else if (m_busy) begin
        if (m_lo) begin m_ph = 1; m_t = 0; end
        else if (m_hi) begin
          m_ph = 0; m_t = 0; m_ptr = (m_ptr + 1) % 32;
          if (m_cnt == 0) m_busy = 0; else m_cnt--;
        end else m_t++;
      end else if (ctl_we) begin
        m_cnt = ctl_wdata[12:8]; m_use = ctl_wdata[7]; m_ptr = ctl_wdata[6:2];
        m_busy = ctl_wdata[1]; m_dir = ctl_wdata[0]; m_ph = 0; m_t = 0;
      end
    end
  end

  bit run_cmp = 0;
  int falls = 0;
  logic prev_re = 1'b1, prev_we = 1'b1;
  always @(negedge clk) if (run_cmp) begin
    chk(ctl_rdata[12:2] == 11'((m_cnt << 6) | (m_use << 5) | m_ptr), "R6",
        "ctl fields", ctl_rdata[12:2], (m_cnt << 6) | (m_use << 5) | m_ptr);
    chk(ctl_rdata[1] == m_busy[0], "R7", "start", ctl_rdata[1], m_busy);
    chk(nf_re_n == !(m_busy && m_dir && !m_ph), "R3", "re_n", nf_re_n,
        !(m_busy && m_dir && !m_ph));
    chk(nf_we_n == !(m_busy && !m_dir && !m_ph), "R3", "we_n", nf_we_n,
        !(m_busy && !m_dir && !m_ph));
    chk(nf_io_oe == (m_busy && !m_dir), "R3", "oe", nf_io_oe, m_busy && !m_dir);
    if (nf_io_oe)
      chk(nf_io_out == 8'(m_use ? m_mem[m_ptr] : m_dreg), "R5", "io_out",
          nf_io_out, m_use ? m_mem[m_ptr] : m_dreg & 255);
    chk(dreg_rdata == 16'(m_dreg), "R4", "dreg", dreg_rdata, m_dreg);
    chk(irq == m_irq[0], "R10", "irq", irq, m_irq);
    chk(buf_rdata == 8'(m_brd), "R11", "buf_rdata", buf_rdata, m_brd);
    if ((prev_re && !nf_re_n) || (prev_we && !nf_we_n)) falls++;
    prev_re = nf_re_n; prev_we = nf_we_n;
  end

  always @(negedge clk) nf_io_in <= nf_io_in * 8'd5 + 8'd3;

  function automatic logic [12:0] cw(int c, int ub, int p, int st, int d);
    return {5'(c), 1'(ub), 5'(p), 1'(st), 1'(d)};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic ctl(input logic [12:0] w);
    ctl_wdata = w; ctl_we = 1'b1; tick(); ctl_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && ctl_rdata[1]; i++) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    chk(0, "R1", "watchdog", 0, 1);
    summary();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk(ctl_rdata == 0, "R1", "ctl after reset", ctl_rdata, 0);
    chk(nf_re_n && nf_we_n && !nf_io_oe, "R1", "pins idle", {nf_re_n, nf_we_n, nf_io_oe}, 3'b110);
    chk(irq == 0 && dreg_rdata == 0, "R1", "irq/dreg", {irq, dreg_rdata}, 0);
    rst_n = 1'b1; tick();
    run_cmp = 1;
    for (int i = 0; i < 32; i++) begin
      buf_addr = 5'(i); buf_wdata = 8'(i * 7 + 3); buf_we = 1'b1; tick();
    end
    buf_we = 1'b0;
    dreg_wdata = 16'h1234; dreg_we = 1'b1; tick(); dreg_we = 1'b0;

    // R2 R5 R6: 4-byte write from buffer, location wraps from 30
    irq_en = 1'b1; falls = 0;
    ctl(cw(3, 1, 30, 1, 0));
    // R8 writes while busy
    ctl(cw(0, 0, 0, 0, 1));
    dreg_wdata = 16'hdead; dreg_we = 1'b1; buf_addr = 5'd30; buf_wdata = 8'hee; buf_we = 1'b1;
    tick(); dreg_we = 1'b0; buf_we = 1'b0;
    chk(ctl_rdata[0] == 1'b0 && ctl_rdata[7] == 1'b1, "R8", "mode kept", ctl_rdata[7:0], 8'h80);
    wait_idle();
    chk(falls == 4, "R2", "byte count", falls, 4);
    chk(ctl_rdata[6:2] == 5'd2, "R6", "location wrap", ctl_rdata[6:2], 2);
    chk(irq == 1'b1, "R10", "irq set", irq, 1);
    chk(dreg_rdata == 16'h1234, "R8", "dreg kept", dreg_rdata, 16'h1234);
    tick(); chk(irq == 1'b1, "R10", "irq held", irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;

    // R4 read 5 bytes into buffer, then R11 read back
    falls = 0;
    ctl(cw(4, 1, 5, 1, 1));
    wait_idle();
    chk(falls == 5, "R2", "read byte count", falls, 5);
    for (int i = 5; i < 10; i++) begin
      buf_addr = 5'(i); buf_re = 1'b1; tick(); buf_re = 1'b0;
      chk(buf_rdata == 8'(m_mem[i]), "R11", "latency read", buf_rdata, m_mem[i]);
    end
    buf_addr = 5'd30; buf_re = 1'b1; tick(); buf_re = 1'b0;
    chk(buf_rdata == 8'd213, "R8", "buffer not overwritten", buf_rdata, 213);

    // R4 read 2 bytes into data register
    ctl(cw(1, 0, 0, 1, 1)); wait_idle();

    // R5 single byte write from data register, no interrupt enabled
    irq_en = 1'b0; irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    ctl(cw(0, 0, 0, 1, 0)); wait_idle(); tick();
    chk(irq == 1'b0, "R10", "irq disabled", irq, 0);

    // R9 abort a 32-byte write, same cycle as a control write
    irq_en = 1'b1;
    ctl(cw(31, 1, 0, 1, 0));
    for (int i = 0; i < 20; i++) tick();
    soft_rst = 1'b1; ctl(cw(2, 0, 9, 1, 1)); soft_rst = 1'b0;
    chk(!ctl_rdata[1] && nf_we_n && nf_re_n, "R9", "aborted", ctl_rdata[1], 0);
    chk(ctl_rdata[0] == 1'b0, "R9", "write ignored", ctl_rdata[0], 0);
    tick(); chk(irq == 1'b0, "R9", "no irq after abort", irq, 0);

    // R10 completion coincides with clear
    ctl(cw(1, 1, 3, 1, 0));
    for (int i = 0; i < 100 && !(m_busy && m_ph && m_t == HI-1 && m_cnt == 0); i++) tick();
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk(irq == 1'b1, "R10", "set beats clear", irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;

    // R9 soft reset on the completing cycle
    ctl(cw(0, 0, 0, 1, 1));
    for (int i = 0; i < 100 && !(m_busy && m_ph && m_t == HI-1 && m_cnt == 0); i++) tick();
    soft_rst = 1'b1; tick(); soft_rst = 1'b0; tick();
    chk(irq == 1'b0, "R9", "abort beats completion", irq, 0);

    tick(); tick();
    run_cmp = 0;
    summary();
  end
endmodule